// File: doc/BRIEF.md
# Single-Wire Duty-Ratio Word Decoder

This block recovers an N-bit data word that a transmitter has encoded as the duty cycle of a pulse train on one wire. A free-running timestamp counter is sampled on three consecutive line events: a rising edge, the next falling edge, and the rising edge after that. From these samples the block forms the high time and the period. A sequential divider turns the two counts into a fractional duty ratio. The block then subtracts a programmable calibration offset, undoes the linear 10 %–90 % transmit mapping, and scales the result to an N-bit code.

The decoder works only from the ratio of two counts taken on the same clock. Any drift in that clock cancels, and no conversion to time units is needed. Capture runs continuously: the rising edge that closes one measurement also opens the next, so a steady pulse train yields one word per period. A word is ready one line period plus a fixed decode delay after the rising edge that opened its measurement. If the line goes quiet for too long, the capture logic drops back to waiting for a rising edge and raises a timeout flag.

Top module: `duty_word_decoder`

## Requirements
- R1: The line input is resynchronised through SYNC_STAGES flops before edge detection, and the timestamp difference between edges equals the number of clock cycles the line spent in each level.
- R2: A measurement needs a rising edge, then a falling edge, then a rising edge. A falling edge seen while waiting for the first rising edge is ignored, and a rising edge followed only by a falling edge produces no word.
- R3: Capture is continuous. K+1 rising edges that bound K complete periods produce K words.
- R4: The duty quotient is q = floor(on × 2^FRAC_W / period), where on is the high-time count and period is the count between rising edges.
- R5: The unsigned value offset_i, in units of 2^-FRAC_W, is subtracted from q before mapping. It is sampled when the word is produced.
- R6: With a = q − offset − round(0.1 × 2^FRAC_W), the code is floor((5·a·2^OUT_W + 2^(FRAC_W+1)) / 2^(FRAC_W+2)), which is (a/2^FRAC_W) × 1.25 × 2^OUT_W rounded to nearest.
- R7: The code is clamped. Where a ≤ 0 the code is 0, and where the formula exceeds 2^OUT_W − 1 the code is 2^OUT_W − 1.
- R8: code_vld_o is high for exactly one cycle per word, and code_o holds its value between strobes.
- R9: If no rising edge occurs for TIMEOUT_CYC cycles, timeout_o goes to 1 and the capture state returns to waiting for a first rising edge. The next rising edge clears timeout_o.
- R10: The timestamp counter wraps modulo 2^TS_W, and wrap between edges does not affect the result while the period is below 2^TS_W.
- R11: After reset, code_o is 0, code_vld_o is 0 and timeout_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; timestamp counter and all logic |
| rst_ni | input | 1 | Active-low synchronous reset |
| pwm_i | input | 1 | Asynchronous encoded pulse line |
| offset_i | input | FRAC_W | Calibration offset subtracted from the duty quotient |
| code_o | output | OUT_W | Decoded word |
| code_vld_o | output | 1 | One-cycle strobe marking a new word |
| timeout_o | output | 1 | Set when no rising edge has arrived within TIMEOUT_CYC cycles |

## Verification
The bench builds the decoder with an 8-bit timestamp, a 16-bit quotient, a 12-bit code and a 200-cycle timeout. The narrow timestamp makes the counter wrap many times within each vector, which exercises the modulo difference. The short timeout lets the bench force the idle state between vectors and test the ignored-falling-edge case quickly. Periods of 64 to 120 cycles keep the divider latency inside a period. Duties at and beyond the band edges, and a large offset, drive both clamps.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
   typedef enum logic [1:0] {
      CAP_IDLE      = 2'd0,
      CAP_WAIT_FALL = 2'd1,
      CAP_WAIT_RISE = 2'd2
   } cap_state_e;
endpackage

// File: rtl/dwd_edge_sync.sv
module dwd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dwd_edge_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i <= STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= line_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (!rst_ni) chain_q[i] <= 1'b0;
               else         chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
   assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/dwd_capture.sv
module dwd_capture
   import dwd_pkg::*;
#(
   parameter int TS_W    = 16,
   parameter int TIMEOUT = 50000
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            rise_i,
   input  logic            fall_i,
   output logic            start_o,
   output logic [TS_W-1:0] on_o,
   output logic [TS_W-1:0] per_o,
   output logic            timeout_o
);
   localparam int TO_W = $clog2(TIMEOUT + 1);

   generate
      if (TIMEOUT < 2 || TIMEOUT >= (2 ** TS_W)) begin : g_bad_timeout
         $error("dwd_capture: TIMEOUT must lie in [2, 2**TS_W)");
      end
   endgenerate

   cap_state_e      state_q;
   logic [TS_W-1:0] stamp_q;
   logic [TS_W-1:0] t_rise_q;
   logic [TS_W-1:0] t_fall_q;
   logic [TO_W-1:0] quiet_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) stamp_q <= '0;
      else         stamp_q <= stamp_q + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q   <= CAP_IDLE;
         t_rise_q  <= '0;
         t_fall_q  <= '0;
         quiet_q   <= '0;
         start_o   <= 1'b0;
         on_o      <= '0;
         per_o     <= '0;
         timeout_o <= 1'b0;
      end else begin
         start_o <= 1'b0;
         if (rise_i) begin
            quiet_q   <= '0;
            timeout_o <= 1'b0;
            t_rise_q  <= stamp_q;
            state_q   <= CAP_WAIT_FALL;
            if (state_q == CAP_WAIT_RISE) begin
               start_o <= 1'b1;
               on_o    <= t_fall_q - t_rise_q;
               per_o   <= stamp_q - t_rise_q;
            end
         end else begin
            if (fall_i && state_q == CAP_WAIT_FALL) begin
               t_fall_q <= stamp_q;
               state_q  <= CAP_WAIT_RISE;
            end
            if (quiet_q != TO_W'(TIMEOUT)) quiet_q <= quiet_q + 1'b1;
            if (quiet_q == TO_W'(TIMEOUT - 1)) begin
               state_q   <= CAP_IDLE;
               timeout_o <= 1'b1;
            end
         end
      end
   end

   AST_START_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |-> (on_o != '0) && (per_o > on_o)); // R2
   AST_TIMEOUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(timeout_o) |-> state_q == CAP_IDLE); // R9
endmodule

// File: rtl/dwd_frac_div.sv
module dwd_frac_div #(
   parameter int NUM_W = 16,
   parameter int Q_W   = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [NUM_W-1:0] den_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [Q_W-1:0]   quot_o
);
   localparam int CNT_W = $clog2(Q_W + 1);

   logic [NUM_W-1:0] rem_q;
   logic [NUM_W-1:0] den_q;
   logic [CNT_W-1:0] left_q;
   logic [NUM_W:0]   trial;
   logic             take;

   assign trial = {rem_q, 1'b0};
   assign take  = trial >= {1'b0, den_q};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rem_q  <= '0;
         den_q  <= '0;
         left_q <= '0;
         quot_o <= '0;
         busy_o <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !busy_o) begin
            rem_q  <= num_i;
            den_q  <= den_i;
            quot_o <= '0;
            left_q <= CNT_W'(Q_W);
            busy_o <= 1'b1;
         end else if (busy_o) begin
            rem_q  <= take ? NUM_W'(trial - {1'b0, den_q}) : trial[NUM_W-1:0];
            quot_o <= {quot_o[Q_W-2:0], take};
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> rem_q < den_q); // R4
endmodule

// File: rtl/dwd_map.sv
module dwd_map #(
   parameter int Q_W   = 16,
   parameter int OUT_W = 12
) (
   input  logic [Q_W-1:0]   quot_i,
   input  logic [Q_W-1:0]   offset_i,
   output logic [OUT_W-1:0] code_o
);
   localparam int AW  = Q_W + 3;
   localparam int SW  = Q_W + OUT_W + 6;
   localparam int LOW = ((2 ** Q_W) + 5) / 10;

   logic signed [AW-1:0] adj;
   logic [SW-1:0]        scaled;
   logic [SW-1:0]        shifted;

   always_comb begin
      adj     = signed'(AW'(quot_i)) - signed'(AW'(offset_i)) - signed'(AW'(LOW));
      scaled  = SW'(adj[AW-2:0]) * SW'(5);
      scaled  = scaled << OUT_W;
      scaled  = scaled + (SW'(1) << (Q_W + 1));
      shifted = scaled >> (Q_W + 2);
      if (adj[AW-1] || adj == '0)
         code_o = '0;
      else if (shifted > SW'((2 ** OUT_W) - 1))
         code_o = '1;
      else
         code_o = shifted[OUT_W-1:0];
   end
endmodule

// File: rtl/duty_word_decoder.sv
module duty_word_decoder #(
   parameter int TS_W        = 16,
   parameter int FRAC_W      = 16,
   parameter int OUT_W       = 12,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 50000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pwm_i,
   input  logic [FRAC_W-1:0] offset_i,
   output logic [OUT_W-1:0]  code_o,
   output logic              code_vld_o,
   output logic              timeout_o
);
   generate
      if (OUT_W < 1 || OUT_W >= FRAC_W) begin : g_bad_out
         $error("duty_word_decoder: OUT_W must lie in [1, FRAC_W)");
      end
      if (FRAC_W < 4 || TS_W < 4) begin : g_bad_width
         $error("duty_word_decoder: FRAC_W and TS_W must be at least 4");
      end
   endgenerate

   logic              rise, fall;
   logic              start;
   logic [TS_W-1:0]   on_cnt, per_cnt;
   logic              div_busy, div_done;
   logic [FRAC_W-1:0] quot;
   logic [OUT_W-1:0]  mapped;

   dwd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .line_i (pwm_i),
      .rise_o(rise),  .fall_o (fall)
   );

   dwd_capture #(.TS_W(TS_W), .TIMEOUT(TIMEOUT_CYC)) u_cap (
      .clk_i  (clk_i), .rst_ni (rst_ni), .rise_i (rise), .fall_i (fall),
      .start_o(start), .on_o   (on_cnt), .per_o  (per_cnt),
      .timeout_o(timeout_o)
   );

   dwd_frac_div #(.NUM_W(TS_W), .Q_W(FRAC_W)) u_div (
      .clk_i (clk_i),  .rst_ni (rst_ni), .start_i (start),
      .num_i (on_cnt), .den_i  (per_cnt),
      .busy_o(div_busy), .done_o (div_done), .quot_o (quot)
   );

   dwd_map #(.Q_W(FRAC_W), .OUT_W(OUT_W)) u_map (
      .quot_i(quot), .offset_i(offset_i), .code_o(mapped)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         code_o     <= '0;
         code_vld_o <= 1'b0;
      end else begin
         code_vld_o <= div_done;
         if (div_done) code_o <= mapped;
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_vld_o |=> !code_vld_o); // R8
   AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !code_vld_o |-> $stable(code_o)); // R8
   AST_DIV_IDLE_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_done |-> !div_busy); // R3
endmodule

// File: tb/duty_word_decoder_test.sv
`timescale 1ns/1ps
module duty_word_decoder_test;
   localparam int TS_W = 8, FRAC_W = 16, OUT_W = 12, TMO = 200;
   localparam int NV = 10;
   // high cycles, period cycles, offset
   localparam int VEC [NV][3] = '{
      '{50, 100, 0},  '{25, 80, 0},   '{70, 120, 0},   '{33, 64, 0},
      '{10, 100, 0},  '{90, 100, 0},  '{5, 100, 0},    '{97, 100, 0},
      '{50, 100, 1000}, '{60, 100, 40000}
   };

   logic clk = 1'b0, rst_n = 1'b0, pwm = 1'b0;
   logic [FRAC_W-1:0] offset = '0;
   logic [OUT_W-1:0] code;
   logic vld, tmo;
   int checks = 0, failures = 0, nvalid = 0, exp_cur = 0;
   logic prev_vld = 1'b0;
   logic [OUT_W-1:0] prev_code = '0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   duty_word_decoder #(.TS_W(TS_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W),
      .SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) uut (
      .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .offset_i(offset),
      .code_o(code), .code_vld_o(vld), .timeout_o(tmo));

   function automatic int exp_code(int on, int per, int off);
      longint q, a, v;
      q = (longint'(on) << FRAC_W) / per;
      a = q - off - ((longint'(1) << FRAC_W) + 5) / 10;
      if (a <= 0) return 0;
      v = (5 * a * (longint'(1) << OUT_W) + (longint'(1) << (FRAC_W + 1))) >> (FRAC_W + 2);
      if (v > (1 << OUT_W) - 1) v = (1 << OUT_W) - 1;
      return int'(v);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: every word must match the current expectation (R4 R5 R6 R7), strobe rules (R8)
   always @(negedge clk) begin
      if (rst_n) begin
         if (vld) begin
            nvalid++;
            check("R6 word value", int'(code), exp_cur);
            check("R8 strobe width", int'(prev_vld), 0);
         end else if (code != prev_code) begin
            check("R8 code hold", int'(code), int'(prev_code));
         end
      end
      prev_vld  = vld;
      prev_code = code;
   end

   task automatic periods(int hi, int per, int k);
      for (int i = 0; i < k; i++) begin
         pwm = 1'b1; cyc(hi);
         pwm = 1'b0; cyc(per - hi);
      end
   endtask

   initial begin
      int base;
      cyc(4);
      rst_n = 1'b1;
      cyc(1);
      check("R11 reset code", int'(code), 0);
      check("R11 reset valid", int'(vld), 0);
      check("R11 reset timeout", int'(tmo), 0);
      cyc(TMO + 60);
      check("R9 timeout after quiet line", int'(tmo), 1);

      // table-driven vectors; timestamps wrap every 256 cycles (R10)
      for (int v = 0; v < NV; v++) begin
         offset  = FRAC_W'(VEC[v][2]);
         exp_cur = exp_code(VEC[v][0], VEC[v][1], VEC[v][2]);
         base    = nvalid;
         pwm = 1'b1; cyc(4);
         check("R9 rise clears timeout", int'(tmo), 0);
         cyc(VEC[v][0] - 4);
         pwm = 1'b0; cyc(VEC[v][1] - VEC[v][0]);
         periods(VEC[v][0], VEC[v][1], 2);
         pwm = 1'b1; cyc(VEC[v][0]);
         pwm = 1'b0; cyc(TMO + 60);
         check("R3 R10 words per vector", nvalid - base, 3);
         check("R9 timeout after vector", int'(tmo), 1);
      end

      // R2: falling edge in idle ignored; rise+fall alone gives no word
      offset  = '0;
      exp_cur = exp_code(40, 100, 0);
      pwm = 1'b1; cyc(TMO + 60);
      check("R9 timeout with line high", int'(tmo), 1);
      base = nvalid;
      pwm = 1'b0; cyc(60);
      check("R2 idle fall ignored", nvalid - base, 0);
      pwm = 1'b1; cyc(40);
      pwm = 1'b0; cyc(60);
      check("R2 rise and fall only", nvalid - base, 0);
      pwm = 1'b1; cyc(40);
      pwm = 1'b0; cyc(40);
      check("R2 one word after third edge", nvalid - base, 1);
      cyc(TMO + 60);

      // R1 R4: exact cycle counts - 1-cycle change of high time shifts code
      exp_cur = exp_code(51, 100, 0);
      base = nvalid;
      periods(51, 100, 1);
      pwm = 1'b1; cyc(51);
      pwm = 1'b0; cyc(60);
      check("R1 R4 one-cycle resolution", nvalid - base, 1);
      cyc(TMO + 60);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule